// File: doc/BRIEF.md
# Signed Two's-Complement Array Multiplier

This block multiplies two signed operands of N bits each and returns their full signed product of 2N bits. It is purely combinational: no clock, no reset, and no storage. The product follows the operands within the same cycle, after the delay of the adder array.

The structure is a square grid of AND terms that feeds rows of ripple adder cells. Every term that carries exactly one operand sign bit is complemented. The term built from both sign bits is left as it is. A constant one enters the array at weight N, and the top bit of the raw sum is complemented at the output. Together these produce the signed result without any separate sign logic.

Each adder row has N cells. The lowest cell of each row has no carry-in, so it is a half adder, and the others are full adders. For N = 4 that gives 16 AND terms and 12 adder cells. The width is a parameter and is checked at elaboration.

Top module: `bw_signed_mul`

## Requirements
- R1: For every pair of N-bit two's-complement operands, `product` equals the signed product a×b as a 2N-bit two's-complement value (with N = 4, all 256 pairs).
- R2: With N = 4, a = 4'b1111 (−1) and b = 4'b0111 (+7) give product = 8'b1111_1001 (−7).
- R3: If either operand is zero, every product bit is zero.
- R4: Both operands at the most negative value give the positive result 2^(2N−2) (N = 4: 8'b0100_0000, +64), so the top product bit is 0.
- R5: With b = +1, the product equals a sign-extended to 2N bits.
- R6: With b = −1 (all ones), the product equals −a sign-extended to 2N bits, including for the most negative a.
- R7: If both operands are nonzero, product bit 2N−1 equals a[N−1] XOR b[N−1].
- R8: Swapping the operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | Multiplicand, two's complement |
| b | input | N | Multiplier, two's complement |
| product | output | 2N | Signed product, two's complement |

## Verification
The checker evaluates the product only when neither operand carries an unknown bit. It also assumes the operands are stable long enough for the array to settle within a delta cycle. The bench satisfies both conditions by driving known operand values once per clock on the rising edge and sampling the product on the falling edge. It makes two full passes over the operand space, the second with the operands swapped. The sign-combination and edge-value requirements therefore fall inside the exhaustive sweep.

// File: rtl/bw_mul_pkg.sv
package bw_mul_pkg;

   // A partial term is complemented when exactly one of its two bits is a sign bit.
   function automatic logic term_inverted(input int row, input int col, input int n);
      return ((row == n - 1) != (col == n - 1));
   endfunction

   localparam int MIN_WIDTH = 2;
   localparam int MAX_WIDTH = 32;

endpackage

// File: rtl/bw_half_add.sv
module bw_half_add (
   input  logic x,
   input  logic y,
   output logic s,
   output logic co
);
   assign s  = x ^ y;
   assign co = x & y;
endmodule

// File: rtl/bw_full_add.sv
module bw_full_add (
   input  logic x,
   input  logic y,
   input  logic ci,
   output logic s,
   output logic co
);
   logic s_mid;
   logic c_lo;
   logic c_hi;

   bw_half_add u_lo (.x(x),     .y(y),  .s(s_mid), .co(c_lo));
   bw_half_add u_hi (.x(s_mid), .y(ci), .s(s),     .co(c_hi));

   assign co = c_lo | c_hi;
endmodule

// File: rtl/bw_pp_array.sv
module bw_pp_array #(
   parameter int N = 4
) (
   input  logic [N-1:0]         a,
   input  logic [N-1:0]         b,
   output logic [N-1:0][N-1:0]  pp
);
   import bw_mul_pkg::*;

   for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
         if (term_inverted(r, c, N)) begin : g_neg
            assign pp[r][c] = ~(a[c] & b[r]);
         end else begin : g_pos
            assign pp[r][c] = a[c] & b[r];
         end
      end
   end
endmodule

// File: rtl/bw_ripple_rows.sv
module bw_ripple_rows #(
   parameter int N = 4
) (
   input  logic [N-1:0][N-1:0]  pp,
   output logic [2*N-1:0]       raw
);
   localparam int ROWS = N - 1;

   logic [ROWS:1][N-1:0] sum_w;
   logic [ROWS:1][N-1:0] carry_w;

   for (genvar r = 1; r <= ROWS; r++) begin : g_row
      for (genvar k = 0; k < N; k++) begin : g_cell
         logic up_w;

         if (k < N - 1) begin : g_mid
            if (r == 1) begin : g_first
               assign up_w = pp[0][k+1];
            end else begin : g_next
               assign up_w = sum_w[r-1][k+1];
            end
         end else begin : g_top
            if (r == 1) begin : g_inject
               assign up_w = 1'b1;
            end else begin : g_chain
               assign up_w = carry_w[r-1][N-1];
            end
         end

         if (k == 0) begin : g_half
            bw_half_add u_ha (
               .x  (pp[r][0]),
               .y  (up_w),
               .s  (sum_w[r][0]),
               .co (carry_w[r][0])
            );
         end else begin : g_full
            bw_full_add u_fa (
               .x  (pp[r][k]),
               .y  (up_w),
               .ci (carry_w[r][k-1]),
               .s  (sum_w[r][k]),
               .co (carry_w[r][k])
            );
         end
      end
   end

   assign raw[0] = pp[0][0];

   for (genvar r = 1; r <= ROWS; r++) begin : g_low_out
      assign raw[r] = sum_w[r][0];
   end

   for (genvar k = 1; k < N; k++) begin : g_high_out
      assign raw[N-1+k] = sum_w[ROWS][k];
   end

   assign raw[2*N-1] = carry_w[ROWS][N-1];
endmodule

// File: rtl/bw_signed_mul.sv
module bw_signed_mul #(
   parameter int N = 4
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] product
);
   import bw_mul_pkg::*;

   localparam int PW = 2 * N;

   if (N < MIN_WIDTH || N > MAX_WIDTH) begin : g_bad_width
      $error("bw_signed_mul: operand width N out of supported range");
   end

   logic [N-1:0][N-1:0] pp_w;
   logic [PW-1:0]       raw_w;

   bw_pp_array #(.N(N)) u_pp (
      .a  (a),
      .b  (b),
      .pp (pp_w)
   );

   bw_ripple_rows #(.N(N)) u_rows (
      .pp  (pp_w),
      .raw (raw_w)
   );

   assign product = {~raw_w[PW-1], raw_w[PW-2:0]};
endmodule

// File: rtl/bw_signed_mul_chk.sv
module bw_signed_mul_chk #(
   parameter int N = 4
) (
   input logic [N-1:0]   a,
   input logic [N-1:0]   b,
   input logic [2*N-1:0] product
);
   localparam int PW = 2 * N;

   logic signed [PW-1:0] model_w;
   logic signed [PW-1:0] ext_a;
   logic                 known_w;

   always_comb begin
      known_w = !$isunknown({a, b});
      ext_a   = PW'($signed(a));
      model_w = $signed(a) * $signed(b);
   end

   always_comb begin
      if (known_w) begin
         a_r1_signed_product : assert (product == model_w)
            else $error("R1 product %h model %h", product, model_w);

         if (a == '0 || b == '0) begin
            a_r3_zero_operand : assert (product == '0)
               else $error("R3 zero operand gave %h", product);
         end

         if (b == N'(1)) begin
            a_r5_times_one : assert (product == ext_a)
               else $error("R5 product %h", product);
         end

         if (b == '1) begin
            a_r6_times_minus_one : assert (product == PW'(-ext_a))
               else $error("R6 product %h", product);
         end

         if (a != '0 && b != '0) begin
            a_r7_sign_bit : assert (product[PW-1] == (a[N-1] ^ b[N-1]))
               else $error("R7 sign bit %b", product[PW-1]);
         end
      end
   end
endmodule

bind bw_signed_mul bw_signed_mul_chk #(.N(N)) u_chk (
   .a       (a),
   .b       (b),
   .product (product)
);

// File: tb/sim_bw_signed_mul.sv
module sim_bw_signed_mul;
   localparam int N      = 4;
   localparam int PW     = 2 * N;
   localparam int CLK_NS = 10;
   localparam int LIMIT  = 5000;

   typedef struct {
      logic [N-1:0]  a;
      logic [N-1:0]  b;
      logic [PW-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  a = '0;
   logic [N-1:0]  b = '0;
   logic [PW-1:0] product;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   item_t sb_q[$];

   always #(CLK_NS / 2) clk = ~clk;

   bw_signed_mul #(.N(N)) u0 (
      .a       (a),
      .b       (b),
      .product (product)
   );

   function automatic int sval(input logic [N-1:0] v);
      return v[N-1] ? int'(v) - (1 << N) : int'(v);
   endfunction

   function automatic string pick_tag(input logic [N-1:0] x, input logic [N-1:0] y, input bit swapped);
      if (swapped)                                   return "R8";
      if (sval(x) == -1 && sval(y) == 7)             return "R2";
      if (x == '0 || y == '0)                        return "R3";
      if (x == {1'b1, {(N-1){1'b0}}} && y == x)      return "R4";
      if (y == N'(1))                                return "R5";
      if (y == '1)                                   return "R6";
      return "R1";
   endfunction

   task automatic drive(input logic [N-1:0] x, input logic [N-1:0] y, input bit swapped);
      item_t it;
      int    p;
      @(posedge clk);
      a <= x;
      b <= y;
      p = sval(x) * sval(y);
      it.a   = x;
      it.b   = y;
      it.exp = PW'(p);
      it.tag = pick_tag(x, y, swapped);
      sb_q.push_back(it);
   endtask

   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         checks++;
         if (product !== it.exp) begin
            errors++;
            $display("FAIL %s a=%b b=%b actual=%b expected=%b", it.tag, it.a, it.b, product, it.exp);
         end
         if (it.a != '0 && it.b != '0) begin
            checks++;
            if (product[PW-1] !== (it.a[N-1] ^ it.b[N-1])) begin
               errors++;
               $display("FAIL R7 a=%b b=%b actual=%b expected=%b", it.a, it.b,
                        product[PW-1], it.a[N-1] ^ it.b[N-1]);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R3: idle operands of zero
      drive('0, '0, 1'b0);
      // R2: directed case
      drive(4'b1111, 4'b0111, 1'b0);
      // R4: both most negative
      drive(4'b1000, 4'b1000, 1'b0);
      // R1, R5, R6 through the exhaustive sweep
      for (int i = 0; i < (1 << N); i++) begin
         for (int j = 0; j < (1 << N); j++) begin
            drive(N'(i), N'(j), 1'b0);
         end
      end
      // R8: operands swapped
      for (int i = 0; i < (1 << N); i++) begin
         for (int j = 0; j < (1 << N); j++) begin
            drive(N'(j), N'(i), 1'b1);
         end
      end
      @(posedge clk);
      while (sb_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (LIMIT) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule